// File: doc/BRIEF.md
# Register-Offset Load Address Generator

This block handles one class of load: the kind that forms its address from a base register and an index register. It reads the fields of a 32-bit instruction word and presents the base and index register numbers to an external register file. In the same cycle it widens the returned index to 64 bits by zero or sign extension, or passes it through unchanged, and may scale it by the access size. It then adds the result to the base to form the effective address. When the base field names register 31, the stack pointer is used as the base instead, and the stack pointer must be 16-byte aligned.

A legal instruction produces a memory read request with a valid/ready handshake. The request carries the 64-bit address and a byte count of 4 or 8. When the load response arrives, the data is zero-extended to the width of the destination register and written back in that same cycle. An option code that is not allowed raises a one-cycle undefined-instruction flag. A misaligned stack-pointer base raises a one-cycle alignment-fault flag. In both cases no request is issued. The block takes a new instruction only while `busy` is low.

Top module: `regoff_load_agu`

## Requirements
- R1: Instruction fields are: destination `insn[4:0]`, base `insn[9:5]`, index `insn[20:16]`, option `insn[15:13]`, scale enable `insn[12]`, and doubleword select `insn[30]` (1 means an 8-byte load, 0 means a 4-byte load). `rf_idx_base` and `rf_idx_index` show the base and index fields combinationally.
- R2: An instruction accepted with option bit 1 equal to 0 raises `undef_flag` for exactly the next cycle. It issues no memory request and causes no writeback.
- R3: The option code sets how the index is treated. 010 zero-extends the low 32 bits. 110 sign-extends the low 32 bits. 011 and 111 use all 64 bits unchanged.
- R4: When the scale enable bit is 1, the extended index is shifted left by 2 for a word load and by 3 for a doubleword load. When the bit is 0, the index is not shifted.
- R5: A base field of 31 selects `sp` as the base. Any other value selects `rf_base_data`.
- R6: A legal instruction whose base field is 31 and whose `sp[3:0]` is nonzero raises `align_fault` for exactly the next cycle and issues no request. An undefined option takes precedence, so only `undef_flag` rises.
- R7: From the cycle after acceptance, `mem_req_valid` is high and holds the address. The address is base plus shifted index, modulo 2^64. `mem_req_bytes` is 4 or 8. The request stays high with a stable address until it is taken on a cycle where `mem_req_ready` is high.
- R8: Once the request has been taken, the first cycle with `mem_rsp_valid` high asserts `wb_en` combinationally, with `wb_idx` set to the destination field. `wb_data` is the low 32 response bits zero-extended for a word load, or all 64 bits for a doubleword load. A response that arrives before the request has been taken is ignored.
- R9: `busy` is high from the cycle after a legal, aligned acceptance through the writeback cycle. While `busy` is high, `insn_valid` is ignored. After a fault or undefined instruction, `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word present |
| insn | input | 32 | Instruction word |
| busy | output | 1 | Load in flight; new instruction not taken |
| rf_idx_base | output | 5 | Register file read index for base |
| rf_idx_index | output | 5 | Register file read index for index |
| rf_base_data | input | 64 | Base register value |
| rf_index_data | input | 64 | Index register value |
| sp | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 64 | Effective address |
| mem_req_bytes | output | 4 | Access size in bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| wb_en | output | 1 | Destination register write enable |
| wb_idx | output | 5 | Destination register number |
| wb_data | output | 64 | Zero-extended load result |
| undef_flag | output | 1 | Undefined-instruction pulse |
| align_fault | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The overlap of interest is a response arriving while the next instruction is already waiting. In that cycle, writeback fires and `busy` is still high, so the waiting instruction must not be taken until the following cycle. The bench keeps `insn_valid` high between instructions and runs the response line on a fixed period, so that writeback repeatedly meets a pending instruction. A reference model judges the result: it accepts only when it is idle, and its expected `wb_en`, `busy` and request outputs are compared on every clock. Responses that arrive while a request is still unaccepted show the same overlap from the memory side, and these must not write back.

// File: rtl/regoff_load_agu.sv
module regoff_load_agu #(
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  output logic        busy,
  output logic [4:0]  rf_idx_base,
  output logic [4:0]  rf_idx_index,
  input  logic [63:0] rf_base_data,
  input  logic [63:0] rf_index_data,
  input  logic [63:0] sp,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  output logic [3:0]  mem_req_bytes,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        wb_en,
  output logic [4:0]  wb_idx,
  output logic [63:0] wb_data,
  output logic        undef_flag,
  output logic        align_fault
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [63:0] addr_q;
  logic        dbl_q;
  logic [4:0]  rt_q;
  logic        undef_q, align_q;

  wire [4:0] f_rt   = insn[4:0];
  wire [4:0] f_rn   = insn[9:5];
  wire [4:0] f_rm   = insn[20:16];
  wire [2:0] f_opt  = insn[15:13];
  wire       f_s    = insn[12];
  wire       f_dbl  = insn[30];

  assign rf_idx_base  = f_rn;
  assign rf_idx_index = f_rm;
  assign busy = (st != S_IDLE);

  wire accept   = insn_valid && !busy;
  wire legal    = f_opt[1];
  wire use_sp   = (f_rn == 5'd31);
  wire misalign = use_sp && (|sp[SP_ALIGN_BITS-1:0]);
  wire go       = accept && legal && !misalign;

  wire [63:0] base = use_sp ? sp : rf_base_data;

  logic [63:0] idx_ext;
  always_comb begin
    case ({f_opt[2], f_opt[0]})
      2'b00:   idx_ext = {32'b0, rf_index_data[31:0]};
      2'b10:   idx_ext = {{32{rf_index_data[31]}}, rf_index_data[31:0]};
      default: idx_ext = rf_index_data;
    endcase
  end

  wire [1:0]  shamt = f_s ? {1'b1, f_dbl} : 2'b00;
  wire [63:0] ea    = base + (idx_ext << shamt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      dbl_q   <= 1'b0;
      rt_q    <= '0;
      undef_q <= 1'b0;
      align_q <= 1'b0;
    end else begin
      undef_q <= accept && !legal;
      align_q <= accept && legal && misalign;
      case (st)
        S_IDLE: if (go) begin
          st     <= S_REQ;
          addr_q <= ea;
          dbl_q  <= f_dbl;
          rt_q   <= f_rt;
        end
        S_REQ:  if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_bytes = dbl_q ? 4'd8 : 4'd4;
  assign undef_flag    = undef_q;
  assign align_fault   = align_q;
  assign wb_en   = (st == S_WAIT) && mem_rsp_valid;
  assign wb_idx  = rt_q;
  assign wb_data = dbl_q ? mem_rsp_data : {32'b0, mem_rsp_data[31:0]};

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7
  AST_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(insn_valid)); // R9
  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_flag || align_fault) |-> !mem_req_valid && !busy); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_flag && align_fault)); // R6
  AST_WB_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_rsp_valid && !mem_req_valid); // R8
  AST_WB_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !busy); // R9

endmodule

// File: tb/regoff_load_agu_test.sv
module regoff_load_agu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic busy;
  logic [4:0] rf_idx_base, rf_idx_index;
  logic [63:0] rf_base_data, rf_index_data;
  logic [63:0] sp = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [3:0] mem_req_bytes;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic wb_en;
  logic [4:0] wb_idx;
  logic [63:0] wb_data;
  logic undef_flag, align_fault;

  logic [63:0] gpr [32];
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign rf_base_data  = gpr[rf_idx_base];
  assign rf_index_data = gpr[rf_idx_index];

  regoff_load_agu uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .busy(busy),
    .rf_idx_base(rf_idx_base), .rf_idx_index(rf_idx_index),
    .rf_base_data(rf_base_data), .rf_index_data(rf_index_data), .sp(sp),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .undef_flag(undef_flag), .align_fault(align_fault)
  );

  int          m_state = 0;
  logic [63:0] m_addr = '0;
  bit          m_dbl = 0;
  logic [4:0]  m_rt = '0;
  bit          m_undef = 0, m_align = 0;
  string       m_tag = "R3";

  function automatic logic [63:0] model_ea(logic [31:0] w, logic [63:0] b, logic [63:0] x, logic [63:0] s);
    logic [63:0] ix;
    int sh;
    case (w[15:13])
      3'b010: ix = x & 64'h0000_0000_FFFF_FFFF;
      3'b110: ix = 64'(longint'(int'(x[31:0])));
      default: ix = x;
    endcase
    sh = w[12] ? (w[30] ? 3 : 2) : 0;
    return ((w[9:5] == 5'd31) ? s : b) + (ix << sh);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state <= 0; m_undef <= 0; m_align <= 0;
    end else begin
      bit acc, legal, mis;
      acc   = insn_valid && (m_state == 0);
      legal = insn[14];
      mis   = (insn[9:5] == 5'd31) && (sp % 16 != 0);
      m_undef <= acc && !legal;
      m_align <= acc && legal && mis;
      if (acc && legal && !mis) begin
        m_state <= 1;
        m_addr  <= model_ea(insn, gpr[insn[9:5]], gpr[insn[20:16]], sp);
        m_dbl   <= insn[30];
        m_rt    <= insn[4:0];
        m_tag   <= (insn[9:5] == 5'd31) ? "R5" : (insn[12] ? "R4" : "R3");
      end else if (m_state == 1 && mem_req_ready) m_state <= 2;
      else if (m_state == 2 && mem_rsp_valid) m_state <= 0;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      bit ewb;
      ewb = (m_state == 2) && mem_rsp_valid;
      chk(rf_idx_base == insn[9:5] && rf_idx_index == insn[20:16], "R1",
          {rf_idx_base, rf_idx_index}, {insn[9:5], insn[20:16]});
      chk(busy == (m_state != 0), "R9", busy, m_state != 0);
      chk(undef_flag == m_undef, "R2", undef_flag, m_undef);
      chk(align_fault == m_align, "R6", align_fault, m_align);
      chk(mem_req_valid == (m_state == 1), "R7", mem_req_valid, m_state == 1);
      if (m_state == 1) begin
        chk(mem_req_addr == m_addr, {m_tag, " R7"}, mem_req_addr, m_addr);
        chk(mem_req_bytes == (m_dbl ? 8 : 4), "R7", mem_req_bytes, m_dbl ? 8 : 4);
      end
      chk(wb_en == ewb, "R8", wb_en, ewb);
      if (ewb) begin
        logic [63:0] ed;
        ed = m_dbl ? mem_rsp_data : (mem_rsp_data & 64'hFFFF_FFFF);
        chk(wb_idx == m_rt, "R8", wb_idx, m_rt);
        chk(wb_data == ed, "R8", wb_data, ed);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    mem_req_ready <= (cyc % 3 != 0);
    mem_rsp_valid <= (cyc % 4 == 1);
    mem_rsp_data  <= {$urandom, $urandom};
  end

  function automatic logic [31:0] mk(bit dbl, logic [2:0] opt, bit s, logic [4:0] rm, logic [4:0] rn, logic [4:0] rt);
    return {1'b1, dbl, 9'b111000011, rm, opt, s, 2'b10, rn, rt};
  endfunction

  task automatic issue(logic [31:0] w, logic [63:0] spv);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      insn = w; insn_valid = 1'b1; sp = spv;
      #5 acc = !busy;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) gpr[i] = {$urandom, $urandom};
    repeat (3) @(posedge clk);
    #5;
    chk(!busy && !mem_req_valid && !wb_en || !mem_rsp_valid, "R9 reset", busy, 0);
    chk(!undef_flag && !align_fault && !mem_req_valid, "R2 R6 reset",
        {undef_flag, align_fault, mem_req_valid}, 0);
    @(negedge clk); rst_n = 1'b1;

    gpr[1] = 64'h0000_0000_1000_0000; gpr[2] = 64'hFFFF_FFFF_8000_0004;
    issue(mk(0, 3'b010, 1, 2, 1, 3), 0);
    issue(mk(0, 3'b110, 1, 2, 1, 4), 0);
    issue(mk(1, 3'b011, 1, 2, 1, 5), 0);
    issue(mk(1, 3'b111, 0, 2, 1, 6), 0);
    issue(mk(1, 3'b011, 1, 2, 31, 7), 64'h0000_0000_0000_7FF0);
    issue(mk(0, 3'b010, 1, 2, 31, 8), 64'h0000_0000_0000_7FF8);
    issue(mk(0, 3'b000, 1, 2, 31, 9), 64'h0000_0000_0000_7FF4);
    issue(mk(1, 3'b100, 0, 2, 1, 10), 0);
    gpr[11] = 64'hFFFF_FFFF_FFFF_FFF0; gpr[12] = 64'h0000_0000_0000_0010;
    issue(mk(1, 3'b011, 1, 12, 11, 13), 0);
    @(negedge clk); insn_valid = 1'b0;
    repeat (12) @(posedge clk);

    for (int n = 0; n < 400; n++) begin
      logic [2:0] opt;
      logic [4:0] rn;
      logic [63:0] spv;
      opt = ($urandom % 5 == 0) ? 3'($urandom) : {1'($urandom), 1'b1, 1'($urandom)};
      rn  = ($urandom % 3 == 0) ? 5'd31 : 5'($urandom);
      spv = {$urandom, $urandom};
      if ($urandom % 2 == 0) spv[3:0] = 4'h0;
      gpr[$urandom % 32] = {$urandom, $urandom};
      issue(mk(1'($urandom), opt, 1'($urandom), 5'($urandom), rn, 5'($urandom)), spv);
      if (n % 37 == 0) begin
        @(negedge clk); insn_valid = 1'b0;
        repeat (5) @(posedge clk);
      end
    end
    @(negedge clk); insn_valid = 1'b0;
    repeat (12) @(posedge clk);
    #7;
    finish_run();
  end
endmodule